// File: doc/BRIEF.md
# Checksummed Flit Link with Single-Cycle Retry

This block is one hop of an on-chip network link, holding both ends: a sending stage with a small flit queue and a receiving stage with its own input queue. Each 16-bit flit travels beside four check bits. The sending stage computes these bits combinationally from the flit it is driving. The receiving stage recomputes them from the data it receives. If the two sets of bits disagree, it drops the flit and reports the fault on a registered back-channel line.

The sending stage keeps every flit in its queue until one clean cycle has passed after the transfer. When the back-channel line is high, it drives the same flit again in that cycle, taken from the same queue entry. No separate replay store exists. A fault-free transfer therefore adds no cycles, and each detected fault costs exactly one cycle. Faults are caught at the hop, before anything downstream acts on the flit. The channel between the two stages has XOR disturbance inputs so that wire faults can be modelled.

Top module: `crc_retry_link`

## Requirements
- R1: The check bits on `link_crc` are the remainder of D(x)·x^4 divided by x^4 + x + 1. D(x) takes flit bit 15 as the highest-degree coefficient and bit 0 as the lowest. The remainder has bit 3 as the x^3 coefficient.
- R2: A flit accepted on the write side of an empty, fault-free link appears on `link_valid`/`link_data` one cycle after acceptance, and on `out_valid`/`out_data` two cycles after acceptance.
- R3: A flit whose received data and check bits disagree is not stored at the receiving end, and `link_err` is high in the cycle after that transfer.
- R4: While `link_err` is high, the sending stage drives the same flit as in the previous cycle with `link_valid` high, and the receiving end accepts it. A single fault therefore delays delivery by exactly one cycle.
- R5: A flit that is corrupted on several consecutive attempts is retried on every following cycle with no limit. It is delivered once, and before every flit behind it.
- R6: Under any sequence of single-bit disturbances on data or check bits, the flits at the read side match the accepted flits exactly, in value and in order.
- R7: With the read side stalled, the link accepts exactly as many flits as its two queues can hold (8 by default), then holds `in_ready` low. The head flit at the read side stays stable until it is read.
- R8: After reset, `in_ready` is 1 and `out_valid`, `link_valid` and `link_err` are 0.
- R9: A single-bit disturbance confined to the check bits is detected and retried like a data fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write-side flit offered |
| in_data | input | 16 | Write-side flit |
| in_ready | output | 1 | Sending queue has room |
| out_valid | output | 1 | Receiving queue holds a flit |
| out_data | output | 16 | Head flit of the receiving queue |
| out_ready | input | 1 | Read side takes the head flit |
| chan_flip_data | input | 16 | XOR disturbance applied to the data wires in the channel |
| chan_flip_crc | input | 4 | XOR disturbance applied to the check wires in the channel |
| link_valid | output | 1 | Sender drives a flit on the link |
| link_data | output | 16 | Flit as driven by the sender, before disturbance |
| link_crc | output | 4 | Check bits as driven by the sender |
| link_err | output | 1 | Registered back-channel fault flag |

## Verification
A sender pointer that moves on too early would skip a flit or duplicate one. This shows at the read side as a wrong value on the first delivery after an injected fault. A lost confirmation would leak or overcount queue space. That shows as `in_ready` dropping at the wrong fill level under a stalled read side. A receiver that stored a bad flit would deliver an extra word one cycle earlier than expected. The bench catches each of these within a few cycles of the fault, by comparing the delivered stream against the accepted stream.

// File: rtl/flk_pkg.sv
// Package for the checksummed flit link.
// Holds the flit and check widths, the generator taps and the parallel
// check-bit function shared by both ends of the link.
package flk_pkg;

    localparam int FLIT_W = 16;
    localparam int CRC_W  = 4;
    // Generator x^4 + x + 1 without its leading term.
    localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

    // Check bits of one flit, unrolled into a single combinational cone.
    function automatic logic [CRC_W-1:0] crc4(input logic [FLIT_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = FLIT_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/flit_store.sv
// Flit storage array: one synchronous write port and one
// combinational read port at any index.
// Assumes the caller never reads and writes the same live entry at once.
// The array has no reset; the queue pointers decide which entries are valid.
module flit_store #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write one entry per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flk_tx.sv
// Sending stage of the link.
// Queues incoming flits and drives the oldest unsent one with its check bits.
// A transferred flit stays stored, marked pending, until the cycle after its
// transfer passes with the back-channel fault flag low. While that flag is high
// the stage drives the pending flit again.
// Assumes DEPTH is a power of two and at least 2. Also assumes the receiver's
// ready stays high in a retry cycle, which holds because a failed flit is never
// stored.
module flk_tx #(
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [flk_pkg::FLIT_W-1:0] in_data,
    output logic                      in_ready,
    output logic                      link_valid,
    output logic [flk_pkg::FLIT_W-1:0] link_data,
    output logic [flk_pkg::CRC_W-1:0]  link_crc,
    input  logic                      link_ready,
    input  logic                      link_err
);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] last_ptr;
    logic [AW-1:0] drv_ptr;
    logic [CW-1:0] occ;
    logic [CW-1:0] unsent;
    logic          pend;
    logic          push;
    logic          xfer;
    logic          confirm;

    // Occupancy counts the pending flit as well; unsent flits exclude it.
    assign unsent   = occ - CW'(pend);
    assign in_ready = (occ < CW'(DEPTH));
    assign push     = in_valid && in_ready;

    // On a fault the previous flit is driven again, otherwise the next new one.
    assign last_ptr   = rd_ptr - 1'b1;
    assign drv_ptr    = link_err ? last_ptr : rd_ptr;
    assign link_valid = link_err || (unsent != '0);
    assign xfer       = link_valid && link_ready;
    assign confirm    = pend && !link_err;

    flit_store #(
        .W     (flk_pkg::FLIT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (in_data),
        .raddr (drv_ptr),
        .rdata (link_data)
    );

    assign link_crc = flk_pkg::crc4(link_data);

    // Queue pointers, pending mark and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            pend   <= 1'b0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (xfer && !link_err) rd_ptr <= rd_ptr + 1'b1;
            pend <= xfer;
            occ  <= occ + CW'(push) - CW'(confirm);
        end
    end

    AST_TX_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R7
    AST_RETRY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> (link_valid && link_ready && pend)); // R4
    AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> (link_data == $past(link_data))); // R4

endmodule

// File: rtl/flk_rx.sv
// Receiving stage of the link.
// Recomputes the check bits of the arriving flit and stores only the 16 data
// bits of a flit that passes. A failed transfer is dropped and sets the
// registered back-channel fault flag for one cycle.
// Assumes DEPTH is a power of two and at least 2.
module flk_rx #(
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      link_valid,
    input  logic [flk_pkg::FLIT_W-1:0] link_data,
    input  logic [flk_pkg::CRC_W-1:0]  link_crc,
    output logic                      link_ready,
    output logic                      link_err,
    output logic                      out_valid,
    output logic [flk_pkg::FLIT_W-1:0] out_data,
    input  logic                      out_ready
);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          crc_ok;
    logic          xfer;
    logic          push;
    logic          pop;

    assign crc_ok     = (flk_pkg::crc4(link_data) == link_crc);
    assign link_ready = (count < CW'(DEPTH));
    assign xfer       = link_valid && link_ready;
    assign push       = xfer && crc_ok;
    assign out_valid  = (count != '0);
    assign pop        = out_valid && out_ready;

    flit_store #(
        .W     (flk_pkg::FLIT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (link_data),
        .raddr (rd_ptr),
        .rdata (out_data)
    );

    // Input queue pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Fault flag back to the sender: one cycle after a failed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) link_err <= 1'b0;
        else        link_err <= xfer && !crc_ok;
    end

    AST_RX_NO_STORE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> (count <= $past(count))); // R3
    AST_RX_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

// File: rtl/crc_retry_link.sv
// One hop of a network link with its sending and receiving stages.
// The channel in between applies XOR disturbances to the data and check wires.
// The fault flag returns from the receiver to the sender over a single wire.
// Assumes both queue depths are powers of two and at least 2.
module crc_retry_link #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [flk_pkg::FLIT_W-1:0] in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [flk_pkg::FLIT_W-1:0] out_data,
    input  logic                      out_ready,
    input  logic [flk_pkg::FLIT_W-1:0] chan_flip_data,
    input  logic [flk_pkg::CRC_W-1:0]  chan_flip_crc,
    output logic                      link_valid,
    output logic [flk_pkg::FLIT_W-1:0] link_data,
    output logic [flk_pkg::CRC_W-1:0]  link_crc,
    output logic                      link_err
);

    logic                       link_ready;
    logic [flk_pkg::FLIT_W-1:0] rx_data;
    logic [flk_pkg::CRC_W-1:0]  rx_crc;

    flk_tx #(.DEPTH(TX_DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .link_valid (link_valid),
        .link_data  (link_data),
        .link_crc   (link_crc),
        .link_ready (link_ready),
        .link_err   (link_err)
    );

    // Channel model: disturbances flip wires between the two stages.
    assign rx_data = link_data ^ chan_flip_data;
    assign rx_crc  = link_crc ^ chan_flip_crc;

    flk_rx #(.DEPTH(RX_DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_data  (rx_data),
        .link_crc   (rx_crc),
        .link_ready (link_ready),
        .link_err   (link_err),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready)
    );

endmodule

// File: tb/crc_retry_link_tb.sv
module crc_retry_link_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;
    logic [15:0] chan_flip_data = '0;
    logic [3:0]  chan_flip_crc = '0;
    logic        link_valid;
    logic [15:0] link_data;
    logic [3:0]  link_crc;
    logic        link_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    crc_retry_link u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .chan_flip_data(chan_flip_data),
        .chan_flip_crc(chan_flip_crc), .link_valid(link_valid),
        .link_data(link_data), .link_crc(link_crc), .link_err(link_err)
    );

    // Remainder by long division of d * x^4 by x^4 + x + 1.
    function automatic logic [3:0] ref_crc(input logic [15:0] d);
        logic [19:0] r;
        r = {d, 4'b0000};
        for (int i = 19; i >= 4; i--)
            if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
        return r[3:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Waits for the head flit, checks it, then reads it out.
    task automatic expect_out(input logic [15:0] e, input string tag);
        int w;
        w = 0;
        while (!out_valid && w < 20) begin
            step();
            w++;
        end
        chk(out_valid && out_data == e, tag, out_data, e);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
        chk(link_valid == 1'b0, "R8 link_valid after reset", link_valid, 0);
        chk(link_err == 1'b0, "R8 link_err after reset", link_err, 0);
    endtask

    task automatic t_latency();
        in_valid = 1'b1;
        in_data  = 16'h3C5A;
        step();
        in_valid = 1'b0;
        chk(link_valid && link_data == 16'h3C5A, "R2 link one cycle after accept", link_data, 16'h3C5A);
        chk(out_valid == 1'b0, "R2 not yet at read side", out_valid, 0);
        step();
        chk(out_valid && out_data == 16'h3C5A, "R2 read side two cycles after accept", out_data, 16'h3C5A);
        chk(link_err == 1'b0, "R2 no fault on clean transfer", link_err, 0);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R2 single delivery", out_valid, 0);
    endtask

    task automatic t_crc_values();
        logic [15:0] pats [5];
        pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h8000;
        pats[3] = 16'hFFFF; pats[4] = 16'hA5C3;
        for (int k = 0; k < 5; k++) begin
            in_valid = 1'b1;
            in_data  = pats[k];
            step();
            in_valid = 1'b0;
            chk(link_crc == ref_crc(pats[k]), "R1 check bits", link_crc, ref_crc(pats[k]));
            expect_out(pats[k], "R1 flit delivered");
        end
    endtask

    task automatic t_single_fault(input logic [15:0] v, input logic [15:0] fd, input logic [3:0] fc, input string tag);
        in_valid = 1'b1;
        in_data  = v;
        step();
        in_valid = 1'b0;
        chan_flip_data = fd;
        chan_flip_crc  = fc;
        step();
        chan_flip_data = '0;
        chan_flip_crc  = '0;
        chk(link_err == 1'b1, {tag, " R3 fault flag next cycle"}, link_err, 1);
        chk(out_valid == 1'b0, {tag, " R3 bad flit not stored"}, out_valid, 0);
        chk(link_valid && link_data == v, {tag, " R4 same flit redriven"}, link_data, v);
        step();
        chk(link_err == 1'b0, {tag, " R4 retry clean"}, link_err, 0);
        chk(out_valid && out_data == v, {tag, " R4 one extra cycle"}, out_data, v);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        chk(out_valid == 1'b0, {tag, " R4 no duplicate"}, out_valid, 0);
    endtask

    task automatic t_repeat();
        in_valid = 1'b1;
        in_data  = 16'h1111;
        step();
        in_data  = 16'h2222;
        chan_flip_data = 16'h0100;
        step();
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(link_err && link_data == 16'h1111, "R5 retry of same flit", link_data, 16'h1111);
            if (k == 2) chan_flip_data = '0;
            step();
        end
        chk(link_err == 1'b0, "R5 retries end when clean", link_err, 0);
        expect_out(16'h1111, "R5 first flit in order");
        expect_out(16'h2222, "R5 second flit in order");
        chk(out_valid == 1'b0, "R5 delivered once", out_valid, 0);
    endtask

    task automatic t_backpressure();
        int acc;
        acc = 0;
        out_ready = 1'b0;
        for (int k = 0; k < 14; k++) begin
            in_valid = 1'b1;
            in_data  = 16'h4000 + 16'(k);
            #1;
            if (in_ready) acc++;
            step();
        end
        in_valid = 1'b0;
        step();
        step();
        chk(acc == 8, "R7 accepted count with read side stalled", acc, 8);
        chk(in_ready == 1'b0, "R7 in_ready low when full", in_ready, 0);
        chk(out_valid && out_data == 16'h4000, "R7 head flit held", out_data, 16'h4000);
        for (int k = 0; k < 8; k++) expect_out(16'h4000 + 16'(k), "R7 drain order");
        chk(out_valid == 1'b0, "R7 nothing extra after drain", out_valid, 0);
    endtask

    task automatic t_random();
        logic [15:0] sent [300];
        int ns, nr, cyc, bad;
        ns = 0; nr = 0; cyc = 0; bad = 0;
        while ((ns < 300 || nr < 300) && cyc < 5000) begin
            in_valid  = (ns < 300) && ($urandom_range(0, 3) != 0);
            in_data   = 16'($urandom);
            out_ready = ($urandom_range(0, 9) < 7);
            chan_flip_data = '0;
            chan_flip_crc  = '0;
            if (link_valid && $urandom_range(0, 3) == 0) begin
                int b;
                b = $urandom_range(0, 19);
                if (b < 16) chan_flip_data = 16'(1) << b;
                else        chan_flip_crc  = 4'(1) << (b - 16);
            end
            #1;
            if (in_valid && in_ready) begin
                sent[ns] = in_data;
                ns++;
            end
            if (out_valid && out_ready) begin
                if (nr < ns && out_data != sent[nr]) bad++;
                if (nr >= ns) bad++;
                nr++;
            end
            step();
            cyc++;
        end
        in_valid = 1'b0; out_ready = 1'b0;
        chan_flip_data = '0; chan_flip_crc = '0;
        chk(bad == 0, "R6 stream mismatches", bad, 0);
        chk(nr == 300, "R6 delivered count", nr, 300);
        chk(ns == 300, "R6 accepted count", ns, 300);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_crc_values();
        t_single_fault(16'hBEEF, 16'h0010, 4'h0, "data fault");
        t_single_fault(16'h7001, 16'h0000, 4'h8, "R9 check-bit fault");
        t_repeat();
        t_backpressure();
        t_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule